// File: doc/BRIEF.md
# Cascaded Two-Stage Fixed-Priority Interrupt Controller

This block gathers sixteen edge-triggered interrupt sources behind one CPU interrupt line. Two eight-input controllers form the block: a primary unit that talks to the CPU, and a secondary unit whose request output feeds the primary's cascade position, input 2. Each unit keeps a pending register and an in-service register. Each unit uses fixed priority, and the lowest input number has the highest priority.

The CPU sees a level interrupt line. It acknowledges with a one-cycle strobe and reads an 8-bit vector in that same cycle. It finishes a handler by writing an end-of-interrupt byte to one of the two units. A source that sits behind the secondary needs one end-of-interrupt to each unit, and the two writes may come in either order. Vector bases are fixed by parameters: primary inputs map to 0x08 plus the input number, and secondary inputs map to 0x70 plus the input number.

Top module: `irq_cascade_pair`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pending and in-service bit in both units is cleared. `cpu_int` is low in the cycle after that edge.
- R2: A rising edge on a source line sets that line's pending bit at the next clock edge, even while another interrupt is in service. `cpu_int` rises right after that edge when nothing blocks it.
- R3: Each line holds at most one pending request. A further rising edge while its pending bit is set is lost, so the line is served once.
- R4: A unit requests only when its best pending input has a lower index than every in-service input. A pending input of equal or higher index stays blocked.
- R5: While `cpu_int` is high, `cpu_vector` is 0x08+n when primary input n wins (n is not 2). When the cascade input wins, it is 0x70+m, where m is the secondary's winning input.
- R6: A clock edge with `cpu_ack` high and `cpu_int` high sets the winner's in-service bit and clears its pending bit. When the cascade input wins, that one strobe does this in both units.
- R7: Writing byte 0x20 with `cmd_wr` high clears the lowest-index in-service bit of the selected unit. `cmd_sel`=0 selects the primary and `cmd_sel`=1 selects the secondary.
- R8: A command byte other than 0x20 changes no state.
- R9: While the primary's cascade in-service bit is set, no secondary request reaches `cpu_int`, even after the secondary has had its end-of-interrupt.
- R10: If the primary gets its end-of-interrupt first, primary inputs can be served again. The secondary stays silent for inputs of equal or lower priority until it gets its own end-of-interrupt.
- R11: `ext_irq[2]` has no effect, because primary input 2 is taken by the cascade.
- R12: `cpu_ack` while `cpu_int` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq | input | 16 | Source lines: [7:0] to the primary (bit 2 unused), [15:8] to secondary inputs 0..7 |
| cpu_int | output | 1 | Interrupt request to the CPU |
| cpu_ack | input | 1 | One-cycle acknowledge strobe |
| cpu_vector | output | 8 | Vector of the current winner, valid while `cpu_int` is high |
| cmd_wr | input | 1 | Command write strobe |
| cmd_sel | input | 1 | Command target: 0 primary, 1 secondary |
| cmd_data | input | 8 | Command byte; 0x20 is end-of-interrupt |

## Verification
The bound checker watches every cycle for these rules: the reset clearing, a request only when something is pending, the in-service count growing by one on each accepted acknowledge in the affected units, unknown bytes and idle acknowledges leaving in-service state untouched, the vector falling in a legal range, and the cascade being held while its primary in-service bit is set. The two end-of-interrupt orderings, lost duplicate edges, nesting of a higher-priority source during service, and the ignored cascade line need multi-step stories. Only the bench scenarios exercise those, with a behavioural model compared on every clock.

// File: rtl/irqc_pkg.sv
// irqc_pkg: shared constants for the cascaded interrupt controller.
// Assumes an eight-line unit and 8-bit vectors.
package irqc_pkg;
    parameter int          IRQC_LINES    = 8;
    parameter int          IRQC_CASC_POS = 2;
    parameter logic [7:0]  IRQC_EOI_BYTE = 8'h20;
    parameter logic [7:0]  IRQC_PRI_BASE = 8'h08;
    parameter logic [7:0]  IRQC_SEC_BASE = 8'h70;
endpackage

// File: rtl/irqc_prio_enc.sv
// irqc_prio_enc: finds the lowest set bit of a vector (lowest index = highest priority).
// Assumes W >= 2. Purely combinational.
module irqc_prio_enc #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set index is the last one written.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_unit.sv
// irqc_unit: one eight-line fixed-priority controller with pending and in-service registers.
// Assumes: edge inputs are synchronous to clk; when HAS_CASC is set, position
// CASC_POS takes the level casc_in instead of a latched edge; ack and eoi are
// one-cycle strobes already routed to this unit.
module irqc_unit #(
    parameter int W        = 8,
    parameter bit HAS_CASC = 1'b0,
    parameter int CASC_POS = 2,
    localparam int IW      = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  src,
    input  logic          casc_in,
    input  logic          ack,
    input  logic          eoi,
    output logic          int_o,
    output logic [IW-1:0] win_idx,
    output logic [W-1:0]  req_o,
    output logic [W-1:0]  isr_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] LVL_MASK = HAS_CASC ? (ONE << CASC_POS) : '0;

    logic [W-1:0]  src_q, irr_q, isr_q;
    logic [W-1:0]  edge_v, req, set_v, clr_v;
    logic          req_hit, isr_hit, take;
    logic [IW-1:0] req_idx, isr_idx;

    // Pick the request source per position: latched edge or cascade level.
    for (genvar g = 0; g < W; g++) begin : g_req
        if (HAS_CASC && (g == CASC_POS)) begin : g_lvl
            assign req[g] = casc_in;
        end else begin : g_edge
            assign req[g] = irr_q[g];
        end
    end

    if (!HAS_CASC) begin : g_nocasc
        logic casc_unused;
        assign casc_unused = casc_in;
    end

    irqc_prio_enc #(.W(W)) i_req_enc (.vec(req),   .hit(req_hit), .idx(req_idx));
    irqc_prio_enc #(.W(W)) i_isr_enc (.vec(isr_q), .hit(isr_hit), .idx(isr_idx));

    // Request only when the best pending input outranks everything in service.
    always_comb begin
        int_o = req_hit && (!isr_hit || (req_idx < isr_idx));
    end

    // Derive rising edges, acknowledge set mask and end-of-interrupt clear mask.
    always_comb begin
        edge_v = src & ~src_q & ~LVL_MASK;
        take   = ack && int_o;
        set_v  = take ? (ONE << req_idx) : '0;
        clr_v  = (eoi && isr_hit) ? (ONE << isr_idx) : '0;
    end

    // Register update: edge history, pending and in-service bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            irr_q <= '0;
            isr_q <= '0;
        end else begin
            src_q <= src;
            irr_q <= ((irr_q & ~set_v) | edge_v) & ~LVL_MASK;
            isr_q <= (isr_q & ~clr_v) | set_v;
        end
    end

    assign win_idx = req_idx;
    assign req_o   = req;
    assign isr_o   = isr_q;
endmodule

// File: rtl/irq_cascade_pair.sv
// irq_cascade_pair: primary and secondary controller with the secondary cascaded
// into primary input CASC_POS. Assumes a one-cycle cpu_ack strobe, with the
// vector read in that same cycle, and one command write per cmd_wr strobe.
module irq_cascade_pair
    import irqc_pkg::*;
#(
    parameter int         LINES    = IRQC_LINES,
    parameter int         CASC_POS = IRQC_CASC_POS,
    parameter logic [7:0] EOI_BYTE = IRQC_EOI_BYTE,
    parameter logic [7:0] PRI_BASE = IRQC_PRI_BASE,
    parameter logic [7:0] SEC_BASE = IRQC_SEC_BASE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*LINES-1:0] ext_irq,
    output logic               cpu_int,
    input  logic               cpu_ack,
    output logic [7:0]         cpu_vector,
    input  logic               cmd_wr,
    input  logic               cmd_sel,
    input  logic [7:0]         cmd_data
);
    localparam int IDX_W = $clog2(LINES);

    logic             sec_int, prim_int;
    logic             sec_ack, eoi_prim, eoi_sec;
    logic [IDX_W-1:0] prim_win, sec_win;
    logic [LINES-1:0] prim_req, prim_isr, sec_req, sec_isr;

    // Decode command writes into per-unit end-of-interrupt strobes.
    always_comb begin
        eoi_prim = cmd_wr && !cmd_sel && (cmd_data == EOI_BYTE);
        eoi_sec  = cmd_wr &&  cmd_sel && (cmd_data == EOI_BYTE);
    end

    // Forward the acknowledge to the secondary only when the cascade wins.
    always_comb begin
        sec_ack = cpu_ack && prim_int && (prim_win == IDX_W'(CASC_POS));
    end

    irqc_unit #(.W(LINES), .HAS_CASC(1'b0), .CASC_POS(CASC_POS)) i_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (ext_irq[2*LINES-1:LINES]),
        .casc_in (1'b0),
        .ack     (sec_ack),
        .eoi     (eoi_sec),
        .int_o   (sec_int),
        .win_idx (sec_win),
        .req_o   (sec_req),
        .isr_o   (sec_isr)
    );

    irqc_unit #(.W(LINES), .HAS_CASC(1'b1), .CASC_POS(CASC_POS)) i_prim (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (ext_irq[LINES-1:0]),
        .casc_in (sec_int),
        .ack     (cpu_ack),
        .eoi     (eoi_prim),
        .int_o   (prim_int),
        .win_idx (prim_win),
        .req_o   (prim_req),
        .isr_o   (prim_isr)
    );

    // Vector select: cascade winner takes the secondary base and index.
    always_comb begin
        if (prim_win == IDX_W'(CASC_POS)) begin
            cpu_vector = SEC_BASE + 8'(sec_win);
        end else begin
            cpu_vector = PRI_BASE + 8'(prim_win);
        end
    end

    assign cpu_int = prim_int;

    logic [LINES-1:0] sec_req_unused;
    assign sec_req_unused = sec_req;
endmodule

// File: rtl/irqc_checker.sv
// irqc_checker: cycle-level rules for irq_cascade_pair, attached by bind.
// Assumes the top's internal unit signals are visible by name in its scope.
module irqc_checker #(
    parameter int         LINES    = 8,
    parameter int         CASC_POS = 2,
    parameter logic [7:0] EOI_BYTE = 8'h20,
    parameter logic [7:0] PRI_BASE = 8'h08,
    parameter logic [7:0] SEC_BASE = 8'h70,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_int,
    input logic             cpu_ack,
    input logic [7:0]       cpu_vector,
    input logic             cmd_wr,
    input logic [7:0]       cmd_data,
    input logic [LINES-1:0] prim_req,
    input logic [LINES-1:0] prim_isr,
    input logic [LINES-1:0] sec_isr,
    input logic [IDX_W-1:0] prim_win
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (prim_isr == '0) && (sec_isr == '0) && !cpu_int); // R1
    AST_INT_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n) cpu_int |-> (|prim_req)); // R4
    AST_ACK_GROWS_PRIM: assert property (@(posedge clk) disable iff (!rst_n) (cpu_ack && cpu_int && !cmd_wr) |=> ($countones(prim_isr) == $past($countones(prim_isr)) + 1)); // R6
    AST_ACK_GROWS_SEC: assert property (@(posedge clk) disable iff (!rst_n) (cpu_ack && cpu_int && (prim_win == IDX_W'(CASC_POS)) && !cmd_wr) |=> ($countones(sec_isr) == $past($countones(sec_isr)) + 1)); // R6
    AST_IDLE_ACK_INERT: assert property (@(posedge clk) disable iff (!rst_n) (cpu_ack && !cpu_int && !cmd_wr) |=> ($stable(prim_isr) && $stable(sec_isr))); // R12
    AST_FOREIGN_BYTE_INERT: assert property (@(posedge clk) disable iff (!rst_n) (cmd_wr && (cmd_data != EOI_BYTE) && !(cpu_ack && cpu_int)) |=> ($stable(prim_isr) && $stable(sec_isr))); // R8
    AST_CASC_HELD: assert property (@(posedge clk) disable iff (!rst_n) prim_isr[CASC_POS] |-> !(cpu_int && (prim_win == IDX_W'(CASC_POS)))); // R9
    AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) (cpu_int && cpu_ack) |-> (((cpu_vector >= PRI_BASE) && (cpu_vector < PRI_BASE + 8'(LINES)) && (cpu_vector != PRI_BASE + 8'(CASC_POS))) || ((cpu_vector >= SEC_BASE) && (cpu_vector < SEC_BASE + 8'(LINES))))); // R5
endmodule

bind irq_cascade_pair irqc_checker #(
    .LINES(LINES), .CASC_POS(CASC_POS), .EOI_BYTE(EOI_BYTE),
    .PRI_BASE(PRI_BASE), .SEC_BASE(SEC_BASE)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cpu_int(cpu_int), .cpu_ack(cpu_ack),
    .cpu_vector(cpu_vector), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .prim_req(prim_req), .prim_isr(prim_isr), .sec_isr(sec_isr),
    .prim_win(prim_win)
);

// File: tb/test_irq_cascade_pair.sv
module test_irq_cascade_pair;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] ext_irq;
    logic        cpu_ack, cmd_wr, cmd_sel;
    logic [7:0]  cmd_data;
    logic        cpu_int;
    logic [7:0]  cpu_vector;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  started = 1'b0;

    always #5 clk = ~clk;

    irq_cascade_pair i_irq_cascade_pair (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .cpu_int(cpu_int),
        .cpu_ack(cpu_ack), .cpu_vector(cpu_vector), .cmd_wr(cmd_wr),
        .cmd_sel(cmd_sel), .cmd_data(cmd_data)
    );

    // Behavioural reference: bits 0..7 primary, 8..15 secondary.
    logic [15:0] m_irr, m_isr, m_prev;

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic bit wants(input logic [7:0] req, input logic [7:0] svc);
        return (lowest(req) < 8) && (lowest(req) < lowest(svc));
    endfunction

    function automatic logic [7:0] m_preq();
        logic [7:0] r;
        r = m_irr[7:0];
        r[2] = wants(m_irr[15:8], m_isr[15:8]);
        return r;
    endfunction

    function automatic bit m_int();
        return wants(m_preq(), m_isr[7:0]);
    endfunction

    function automatic logic [7:0] m_vec();
        int w;
        w = lowest(m_preq());
        if (w == 2) return 8'h70 + 8'(lowest(m_irr[15:8]));
        return 8'h08 + 8'(w);
    endfunction

    always @(posedge clk) begin
        logic [15:0] setv, clrv, edges;
        int pw, sw, sv, base;
        started = 1'b1;
        if (!rst_n) begin
            m_irr = '0; m_isr = '0; m_prev = '0;
        end else begin
            setv = '0; clrv = '0;
            if (cpu_ack && m_int()) begin
                pw = lowest(m_preq());
                setv[pw] = 1'b1;
                if (pw == 2) begin
                    sw = lowest(m_irr[15:8]);
                    setv[8 + sw] = 1'b1;
                end
            end
            if (cmd_wr && cmd_data == 8'h20) begin
                base = cmd_sel ? 8 : 0;
                sv = lowest(m_isr[base +: 8]);
                if (sv < 8) clrv[base + sv] = 1'b1;
            end
            edges = ext_irq & ~m_prev;
            edges[2] = 1'b0;
            m_isr = (m_isr & ~clrv) | setv;
            m_irr = (m_irr & ~setv) | edges;
            m_irr[2] = 1'b0;
            m_prev = ext_irq;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            n_chk++;
            if (cpu_int !== m_int()) begin
                n_fail++;
                $display("FAIL R4 model cpu_int: actual %0b expected %0b at %0t", cpu_int, m_int(), $time);
            end
            if (m_int()) begin
                n_chk++;
                if (cpu_vector !== m_vec()) begin
                    n_fail++;
                    $display("FAIL R5 model vector: actual %02h expected %02h at %0t", cpu_vector, m_vec(), $time);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_int(input logic exp, input string tag);
        check(cpu_int === exp, tag, int'(cpu_int), int'(exp));
    endtask

    task automatic pulse(input int line);
        @(negedge clk) ext_irq[line] = 1'b1;
        @(negedge clk) ext_irq[line] = 1'b0;
    endtask

    task automatic do_ack(input logic [7:0] exp, input string tag);
        @(negedge clk) cpu_ack = 1'b1;
        #1 check(cpu_vector === exp, tag, int'(cpu_vector), int'(exp));
        @(negedge clk) cpu_ack = 1'b0;
    endtask

    task automatic cmd(input logic sel, input logic [7:0] data);
        @(negedge clk) begin cmd_wr = 1'b1; cmd_sel = sel; cmd_data = data; end
        @(negedge clk) cmd_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ext_irq = '0; cpu_ack = 1'b0; cmd_wr = 1'b0; cmd_sel = 1'b0; cmd_data = '0;
        repeat (3) @(negedge clk);
        chk_int(1'b0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R5 / R6: a plain primary source.
        pulse(5);
        chk_int(1'b1, "R2 request after edge");
        do_ack(8'h0D, "R5 primary vector 5");
        chk_int(1'b0, "R6 pending cleared on ack");
        cmd(1'b0, 8'h20);

        // R3: two edges while pending give one service.
        pulse(4); pulse(4);
        do_ack(8'h0C, "R3 vector 4");
        cmd(1'b0, 8'h20);
        @(negedge clk);
        chk_int(1'b0, "R3 second edge lost");

        // R4 / R7: blocking by priority, nesting, and EOI order of clearing.
        pulse(6);
        do_ack(8'h0E, "R4 vector 6");
        pulse(6);
        chk_int(1'b0, "R4 equal priority blocked");
        pulse(7);
        chk_int(1'b0, "R4 lower priority blocked");
        pulse(3);
        chk_int(1'b1, "R2 nested higher priority");
        do_ack(8'h0B, "R4 vector 3");
        cmd(1'b0, 8'h20);
        chk_int(1'b0, "R7 only highest in-service cleared");
        cmd(1'b0, 8'h20);
        do_ack(8'h0E, "R7 vector 6 after clear");
        cmd(1'b0, 8'h20);
        do_ack(8'h0F, "R4 vector 7");
        cmd(1'b0, 8'h20);
        chk_int(1'b0, "R7 all clear");

        // R8: foreign byte, and EOI to an empty secondary, change nothing.
        pulse(1);
        do_ack(8'h09, "R8 vector 1");
        cmd(1'b0, 8'h21);
        cmd(1'b1, 8'h20);
        pulse(5);
        chk_int(1'b0, "R8 input 1 still in service");
        cmd(1'b0, 8'h20);
        do_ack(8'h0D, "R8 vector 5 after real EOI");
        cmd(1'b0, 8'h20);

        // R11: the cascade-position line is ignored.
        pulse(2);
        @(negedge clk);
        chk_int(1'b0, "R11 ext line 2 ignored");

        // R12: idle acknowledge has no effect.
        @(negedge clk) cpu_ack = 1'b1;
        @(negedge clk) cpu_ack = 1'b0;
        pulse(6);
        chk_int(1'b1, "R12 idle ack left no in-service");
        do_ack(8'h0E, "R12 vector 6");
        cmd(1'b0, 8'h20);

        // R9: secondary EOI first, cascade stays held until primary EOI.
        pulse(11);
        do_ack(8'h73, "R5 secondary vector 3");
        pulse(13);
        cmd(1'b1, 8'h20);
        chk_int(1'b0, "R9 held after secondary EOI");
        pulse(9);
        chk_int(1'b0, "R9 higher secondary still held");
        cmd(1'b0, 8'h20);
        do_ack(8'h71, "R9 vector after primary EOI");
        cmd(1'b1, 8'h20); cmd(1'b0, 8'h20);
        do_ack(8'h75, "R9 vector 5 secondary");
        cmd(1'b1, 8'h20); cmd(1'b0, 8'h20);
        chk_int(1'b0, "R9 drained");

        // R10: primary EOI first.
        pulse(8);
        do_ack(8'h70, "R10 vector secondary 0");
        pulse(12);
        cmd(1'b0, 8'h20);
        chk_int(1'b0, "R10 secondary silent before own EOI");
        pulse(6);
        chk_int(1'b1, "R10 primary served again");
        do_ack(8'h0E, "R10 primary vector 6");
        cmd(1'b0, 8'h20);
        chk_int(1'b0, "R10 still silent");
        cmd(1'b1, 8'h20);
        do_ack(8'h74, "R10 secondary 4 after own EOI");
        cmd(1'b1, 8'h20); cmd(1'b0, 8'h20);

        // R6: one strobe marks both units.
        pulse(15);
        do_ack(8'h77, "R6 vector secondary 7");
        pulse(3);
        chk_int(1'b0, "R6 primary cascade in service");
        pulse(14);
        chk_int(1'b0, "R6 cascade blocks secondary 6");
        cmd(1'b1, 8'h20); cmd(1'b0, 8'h20);
        do_ack(8'h76, "R6 cascade outranks primary 3");
        cmd(1'b1, 8'h20); cmd(1'b0, 8'h20);
        do_ack(8'h0B, "R6 primary 3 last");
        cmd(1'b0, 8'h20);

        // R1: reset in the middle drops pending work.
        pulse(5);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk_int(1'b0, "R1 mid-run reset");
        @(negedge clk);
        chk_int(1'b0, "R1 pending gone");

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule